// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

The block measures time on external digital inputs with a 16-bit counter that advances only on cycles where a timer tick enable is high. A start condition and a stop condition are each formed from one input pin, picked by its own select field, and an edge type: rising, falling, either, or none. Every input passes through a two-flop synchronizer and an edge detector before it can act.

Three modes set what the counter does. Gated mode counts from a start event to a stop event, which measures a pulse width or the delay between two signals. Timestamp mode lets the counter run freely, and each start or stop event copies the count into a latch register. One-shot mode counts from a software arm pulse until the stop event and then holds the count until software arms it again. A sticky rollover flag records counter wrap-around. A clear pulse zeroes the counter and the rollover flag. The captured value is read one byte at a time, and reading the high byte freezes the low byte so that the pair is consistent. A done flag marks each capture and can drive an interrupt.

Top module: `edge_capture`

## Requirements
- R1: After reset, rdByte is 0 and capDone, rollover and irq are all 0.
- R2: An edge code selects the event: 2'b00 never fires, bit 0 fires on a rising edge and bit 1 on a falling edge, so 2'b11 fires on either edge. An edge that arrives on a pin just before rising clock edge q is acted on at clock edge q+2.
- R3: startSel and stopSel each pick a pin by index. A select value of NPINS or above (for example 4'hF) picks no pin, and no event fires.
- R4: Gated mode (mode 2'b01). A start event begins counting and a stop event ends it and latches the count. The count includes the tick of the stop cycle, so with tick held high the latch holds the pulse width in clock cycles. A stop event that arrives while counting is idle is ignored.
- R5: The counter advances only on cycles where tick is 1.
- R6: Timestamp mode (mode 2'b10). The counter runs on every tick, and each start event and each stop event latches the count. The difference between two latched values equals the number of ticks between the two events.
- R7: One-shot mode (mode 2'b11). An arm pulse starts counting at the next clock edge. A stop event halts counting and latches the count, so with tick high the value is the delay from arm to the pin edge plus 2. Start events are ignored. After the halt the count holds until the next arm, and counting then resumes from the held value.
- R8: rollover sets when the counter wraps from 16'hFFFF to 0 and stays set. It raises neither capDone nor irq.
- R9: A clr pulse zeroes the counter and rollover at the next clock edge, and takes priority over a tick in that cycle.
- R10: capDone sets on every capture and clears on stRead. A capture in the same cycle as stRead leaves it set. irq is capDone gated by irqEn.
- R11: rdHigh returns latch bits 15:8 on rdByte after one clock and freezes bits 7:0. A later rdLow returns the frozen low byte, even if a new capture has happened since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable from a timer |
| pins | input | NPINS | Asynchronous input pins |
| startSel | input | SELW | Start pin index |
| stopSel | input | SELW | Stop pin index |
| startEdge | input | 2 | Start edge code |
| stopEdge | input | 2 | Stop edge code |
| mode | input | 2 | 00 off, 01 gated, 10 timestamp, 11 one-shot |
| arm | input | 1 | One-shot start pulse |
| clr | input | 1 | Clear counter and rollover pulse |
| stRead | input | 1 | Status read pulse, clears capDone |
| rdHigh | input | 1 | Read high byte and freeze low byte |
| rdLow | input | 1 | Read frozen low byte |
| irqEn | input | 1 | Interrupt enable |
| rdByte | output | BW | Read data byte |
| capDone | output | 1 | Capture has happened since last status read |
| rollover | output | 1 | Sticky counter wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
The count register and the run state cannot be seen directly. A wrong run state or a miscounted tick therefore shows up only in the next latched value, which can be read through the byte port a few cycles after the stop edge. Each measurement is therefore compared against an exact count of cycles worked out from the synchronizer latency. A halted count that drifts in one-shot mode shows up only at the next arm-and-stop cycle, so the bench re-arms after an idle gap and checks the sum. A lost done flag or a stuck rollover flag shows at its output pin on the very next clock.

// File: rtl/capt_pkg.sv
`timescale 1ns/1ps
package capt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_GATED   = 2'b01,
    MODE_STAMP   = 2'b10,
    MODE_ONESHOT = 2'b11
  } mode_t;

  typedef struct packed {
    logic clr;
    logic inc;
    logic capture;
  } strb_t;
endpackage

// File: rtl/capt_sync.sv
`timescale 1ns/1ps
module capt_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pins[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/capt_ctrl.sv
`timescale 1ns/1ps
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SELW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  input  logic [SELW-1:0]  startSel,
  input  logic [SELW-1:0]  stopSel,
  input  logic [1:0]       startEdge,
  input  logic [1:0]       stopEdge,
  input  mode_t            mode,
  input  logic             tick,
  input  logic             arm,
  input  logic             clrReq,
  input  logic             stRead,
  output strb_t            strb,
  output logic             running,
  output logic             capDone
);
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [SELW:0] PIN_LIMIT = (SELW+1)'(NPINS);

  function automatic logic pickEv(input logic [NPINS-1:0] r,
                                  input logic [NPINS-1:0] f,
                                  input logic [SELW-1:0]  s,
                                  input logic [1:0]       e);
    logic hit;
    hit = 1'b0;
    if ({1'b0, s} < PIN_LIMIT)
      hit = (e[0] & r[s[PW-1:0]]) | (e[1] & f[s[PW-1:0]]);
    return hit;
  endfunction

  logic startEv, stopEv, runNext, capNow;

  assign startEv = pickEv(rise, fall, startSel, startEdge);
  assign stopEv  = pickEv(rise, fall, stopSel, stopEdge);

  always_comb begin
    runNext = 1'b0;
    capNow  = 1'b0;
    unique case (mode)
      MODE_GATED: begin
        if (running) begin
          runNext = ~stopEv;
          capNow  = stopEv;
        end else begin
          runNext = startEv;
        end
      end
      MODE_STAMP: begin
        capNow = startEv | stopEv;
      end
      MODE_ONESHOT: begin
        if (running && stopEv) begin
          runNext = 1'b0;
          capNow  = 1'b1;
        end else begin
          runNext = running | arm;
        end
      end
      default: begin
        runNext = 1'b0;
      end
    endcase
  end

  assign strb.clr     = clrReq;
  assign strb.inc     = tick & (running | (mode == MODE_STAMP));
  assign strb.capture = capNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      capDone <= 1'b0;
    end else begin
      running <= runNext;
      if (capNow)      capDone <= 1'b1;
      else if (stRead) capDone <= 1'b0;
    end
  end

  // R7: a stop event in one-shot mode halts counting
  a_r7_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ONESHOT && running && stopEv) |=> !running);

  // R10: a capture always leaves the done flag set
  a_r10_done_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capDone);
endmodule

// File: rtl/capt_dp.sv
`timescale 1ns/1ps
module capt_dp
  import capt_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strb_t           strb,
  input  logic            rdHigh,
  input  logic            rdLow,
  output logic [2*BW-1:0] count,
  output logic            rollover,
  output logic [BW-1:0]   rdByte
);
  localparam int CW = 2 * BW;
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic [CW-1:0] cntNext, latchQ;
  logic [BW-1:0] lowShadow;

  always_comb begin
    if (strb.clr)      cntNext = '0;
    else if (strb.inc) cntNext = count + 1'b1;
    else               cntNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      rollover <= 1'b0;
    end else begin
      count <= cntNext;
      if (strb.clr)                       rollover <= 1'b0;
      else if (strb.inc && count == MAXC) rollover <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ    <= '0;
      lowShadow <= '0;
      rdByte    <= '0;
    end else begin
      if (strb.capture) latchQ <= cntNext;
      if (rdHigh) begin
        rdByte    <= latchQ[CW-1:BW];
        lowShadow <= latchQ[BW-1:0];
      end else if (rdLow) begin
        rdByte <= lowShadow;
      end
    end
  end

  // R8: rollover stays set until cleared
  a_r8_rollover_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rollover && !strb.clr) |=> rollover);

  // R9: clear empties counter and rollover
  a_r9_clr_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (count == '0 && !rollover));
endmodule

// File: rtl/edge_capture.sv
`timescale 1ns/1ps
module edge_capture
  import capt_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SELW  = 4,
  parameter int BW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [NPINS-1:0] pins,
  input  logic [SELW-1:0]  startSel,
  input  logic [SELW-1:0]  stopSel,
  input  logic [1:0]       startEdge,
  input  logic [1:0]       stopEdge,
  input  logic [1:0]       mode,
  input  logic             arm,
  input  logic             clr,
  input  logic             stRead,
  input  logic             rdHigh,
  input  logic             rdLow,
  input  logic             irqEn,
  output logic [BW-1:0]    rdByte,
  output logic             capDone,
  output logic             rollover,
  output logic             irq
);
  localparam int CW = 2 * BW;

  logic [NPINS-1:0] rise, fall;
  strb_t            strb;
  logic             running;
  logic [CW-1:0]    count;
  mode_t            modeT;

  assign modeT = mode_t'(mode);

  capt_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rstN(rstN), .pins(pins), .rise(rise), .fall(fall)
  );

  capt_ctrl #(.NPINS(NPINS), .SELW(SELW)) u_ctrl (
    .clk(clk), .rstN(rstN), .rise(rise), .fall(fall),
    .startSel(startSel), .stopSel(stopSel),
    .startEdge(startEdge), .stopEdge(stopEdge),
    .mode(modeT), .tick(tick), .arm(arm), .clrReq(clr), .stRead(stRead),
    .strb(strb), .running(running), .capDone(capDone)
  );

  capt_dp #(.BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdHigh(rdHigh), .rdLow(rdLow),
    .count(count), .rollover(rollover), .rdByte(rdByte)
  );

  assign irq = capDone & irqEn;

  // R5: no tick, no movement of the counter
  a_r5_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !clr) |=> $stable(count));

  // R7: a halted one-shot count holds its value
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (modeT == MODE_ONESHOT && !running && !clr) |=> $stable(count));
endmodule

// File: tb/sim_edge_capture.sv
`timescale 1ns/1ps
module sim_edge_capture;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] pins = '0;
  logic [3:0] startSel = '0, stopSel = '0;
  logic [1:0] startEdge = '0, stopEdge = '0, mode = '0;
  logic       arm = 0, clr = 0, stRead = 0, rdHigh = 0, rdLow = 0, irqEn = 0;
  logic [7:0] rdByte;
  logic       capDone, rollover, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  edge_capture u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .pins(pins),
    .startSel(startSel), .stopSel(stopSel),
    .startEdge(startEdge), .stopEdge(stopEdge), .mode(mode),
    .arm(arm), .clr(clr), .stRead(stRead), .rdHigh(rdHigh), .rdLow(rdLow),
    .irqEn(irqEn), .rdByte(rdByte), .capDone(capDone),
    .rollover(rollover), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doClr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic ack();
    stRead = 1'b1; cyc(1); stRead = 1'b0;
  endtask

  task automatic readLatch(output logic [15:0] v);
    rdHigh = 1'b1; cyc(1); rdHigh = 1'b0;
    v[15:8] = rdByte;
    rdLow = 1'b1; cyc(1); rdLow = 1'b0;
    v[7:0] = rdByte;
  endtask

  task automatic testReset();
    chk("R1 rdByte", rdByte, 0);
    chk("R1 capDone", capDone, 0);
    chk("R1 rollover", rollover, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic testGated();
    logic [15:0] v;
    mode = 2'b01; startSel = 4'd0; stopSel = 4'd0;
    startEdge = 2'b01; stopEdge = 2'b10;
    doClr(); ack(); cyc(3);
    pins[0] = 1'b1; cyc(37); pins[0] = 1'b0; cyc(5);
    chk("R4 gated done", capDone, 1);
    readLatch(v);
    chk("R4 gated width 37", v, 37);
    // R3: start and stop on different pins
    startSel = 4'd2; stopSel = 4'd5; stopEdge = 2'b01;
    doClr(); ack(); cyc(2);
    pins[2] = 1'b1; cyc(20); pins[5] = 1'b1; cyc(5);
    readLatch(v);
    chk("R3 two-pin delay 20", v, 20);
    pins[2] = 1'b0; pins[5] = 1'b0; cyc(5); ack();
    // R3 out-of-range start select, R4 stop while idle ignored
    startSel = 4'hF;
    pins[2] = 1'b1; cyc(4); pins[5] = 1'b1; cyc(6);
    chk("R3 R4 no capture", capDone, 0);
    pins[2] = 1'b0; pins[5] = 1'b0; cyc(5);
  endtask

  task automatic testTick();
    logic [15:0] v;
    mode = 2'b01; startSel = 4'd0; stopSel = 4'd0;
    startEdge = 2'b01; stopEdge = 2'b10;
    doClr(); ack(); cyc(2);
    pins[0] = 1'b1; cyc(10); tick = 1'b0; cyc(10); tick = 1'b1; cyc(10);
    pins[0] = 1'b0; cyc(5);
    readLatch(v);
    chk("R5 ticks only 20", v, 20);
  endtask

  task automatic testStamp();
    logic [15:0] a, b;
    mode = 2'b10; startSel = 4'd1; stopSel = 4'hF;
    startEdge = 2'b00; stopEdge = 2'b01;
    ack(); cyc(2);
    pins[1] = 1'b1; cyc(6); pins[1] = 1'b0; cyc(6);
    chk("R2 edge code 00 silent", capDone, 0);
    startEdge = 2'b11; cyc(2);
    pins[1] = 1'b1; cyc(5);
    chk("R6 start latches", capDone, 1);
    readLatch(a); ack();
    cyc(42); pins[1] = 1'b0; cyc(5);
    chk("R2 falling via either", capDone, 1);
    readLatch(b);
    chk("R6 stamp diff 50", b - a, 50);
    ack();
  endtask

  task automatic testOneShot();
    logic [15:0] v;
    mode = 2'b11; startSel = 4'd3; stopSel = 4'd3;
    startEdge = 2'b01; stopEdge = 2'b01;
    doClr(); ack(); cyc(2);
    arm = 1'b1; cyc(1); arm = 1'b0;
    cyc(24); pins[3] = 1'b1; cyc(5);
    readLatch(v);
    chk("R7 one-shot 27", v, 27);
    pins[3] = 1'b0; ack(); cyc(40);
    pins[3] = 1'b1; cyc(5);
    chk("R7 no restart on pin", capDone, 0);
    pins[3] = 1'b0; cyc(3);
    arm = 1'b1; cyc(1); arm = 1'b0;
    cyc(9); pins[3] = 1'b1; cyc(5);
    readLatch(v);
    chk("R7 resume from held 39", v, 39);
    pins[3] = 1'b0; ack(); cyc(3);
  endtask

  task automatic testRollover();
    logic [15:0] v;
    mode = 2'b10; startSel = 4'd1; stopSel = 4'hF;
    startEdge = 2'b01; stopEdge = 2'b01; irqEn = 1'b1;
    doClr(); ack();
    cyc(65540);
    chk("R8 rollover set", rollover, 1);
    chk("R8 no done from wrap", capDone, 0);
    chk("R8 no irq from wrap", irq, 0);
    clr = 1'b1; pins[1] = 1'b1; cyc(1); clr = 1'b0;
    chk("R9 rollover cleared", rollover, 0);
    cyc(4);
    chk("R10 irq enabled", irq, 1);
    readLatch(v);
    chk("R9 count restarts 2", v, 2);
    irqEn = 1'b0; cyc(1);
    chk("R10 irq masked", irq, 0);
    chk("R10 done kept", capDone, 1);
    ack();
    chk("R10 done cleared", capDone, 0);
    pins[1] = 1'b0; cyc(4);
  endtask

  task automatic testBytes();
    mode = 2'b10; startSel = 4'd1; stopSel = 4'd1;
    startEdge = 2'b01; stopEdge = 2'b10;
    ack(); cyc(2);
    clr = 1'b1; pins[1] = 1'b1; cyc(1); clr = 1'b0;
    cyc(4);
    rdHigh = 1'b1; cyc(1); rdHigh = 1'b0;
    chk("R11 high byte", rdByte, 0);
    pins[1] = 1'b0; cyc(5);
    rdLow = 1'b1; cyc(1); rdLow = 1'b0;
    chk("R11 frozen low 2", rdByte, 2);
    rdHigh = 1'b1; cyc(1); rdHigh = 1'b0;
    rdLow = 1'b1; cyc(1); rdLow = 1'b0;
    chk("R11 new low 8", rdByte, 8);
    ack();
    // R10 capture in same cycle as status read keeps flag
    pins[1] = 1'b1; cyc(2);
    stRead = 1'b1; cyc(1); stRead = 1'b0;
    chk("R10 set wins over read", capDone, 1);
    ack(); pins[1] = 1'b0; cyc(4);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testGated();
    testTick();
    testStamp();
    testOneShot();
    testRollover();
    testBytes();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule